// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is a serial peripheral interface master. A host writes characters into a one-entry holding register. The engine moves each character into its shift register as soon as that register is free, so a second character can wait while the first is on the wire. Characters leave back to back with no gap on the serial clock.

While each character shifts out on `mosi`, the engine shifts a character in from `miso`. At the end of the frame that character goes into a one-entry receive buffer. Four flags track the pipeline from holding register to shifter to receive buffer:
- room in the holding register,
- all transmission finished,
- a received character waiting,
- a received character lost because the previous one was never read.

The serial clock comes from a programmable divider. Clock polarity and phase, bit order, character size (8 or 9 bits), receive enable and a hardware slave select are configuration inputs. These inputs are held stable while a transfer is in progress.

Top module: `spi_dbuf_master`

## Requirements
- R1: A write with `wr_en` is accepted when `dre`=1. `dre` reads 0 the next cycle and returns to 1 once the character has moved into the shifter. `txc` is cleared by an accepted write and set when the last character has shifted out and no character is pending.
- R2: A character waiting in the holding register starts at the end of the current frame. The SCK half-period does not change across the boundary, and `ss_n` does not rise between the two frames.
- R3: With `cfg_rx_en`=1, the character shifted in from `miso` is placed in the receive buffer at frame end and `rxc` goes to 1. With `cfg_rx_en`=0, `rxc` stays 0 and the buffer is not written.
- R4: `cfg_nine_bit`=1 sends all of `wr_data[8:0]` and returns nine bits. `cfg_nine_bit`=0 sends `wr_data[7:0]` and returns `rd_data[8]`=0.
- R5: `cfg_lsb_first`=0 puts the most significant bit of the character first on the wire. `cfg_lsb_first`=1 puts bit 0 first. The same order applies to `miso`.
- R6: SCK idles at `cfg_cpol`. Data is sampled on the rising SCK edge when `cfg_cpol`==`cfg_cpha` and on the falling edge otherwise. `mosi` changes only on the opposite edge. With `cfg_cpha`=0, the first bit is valid before the first edge.
- R7: `ovf` is set when a frame completes with `rxc`=1 and no read in that cycle. The new character replaces the old one. A pulse on `ovf_clr` (write-1-to-clear) clears `ovf` and leaves `rxc` unchanged.
- R8: `rd_data` reads 0 whenever `rxc`=0. A pulse on `rd_en` consumes the character and clears `rxc`.
- R9: Each SCK half-period lasts `cfg_baud`+1 system clocks, so SCK is the system clock divided by 2*(`cfg_baud`+1).
- R10: With `cfg_ss_en`=1, `ss_n` falls `cfg_baud`+1 clocks before the first SCK edge of a transfer and rises when `txc` is set. With `cfg_ss_en`=0, `ss_n` stays 1.
- R11: A write while `dre`=0 is ignored, and the pending character goes out unchanged.
- R12: After reset: `dre`=1, `txc`=0, `rxc`=0, `ovf`=0, `ss_n`=1, SCK at `cfg_cpol`, `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: bit 0 first on the wire |
| cfg_nine_bit | input | 1 | 1: 9-bit characters, 0: 8-bit |
| cfg_rx_en | input | 1 | Capture received characters |
| cfg_ss_en | input | 1 | Drive the hardware slave select |
| cfg_baud | input | 8 | Divider value; half-period = value+1 clocks |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send |
| rd_en | input | 1 | Consume the received character |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_data | output | 9 | Received character, 0 when none is waiting |
| dre | output | 1 | Holding register empty |
| txc | output | 1 | All transmission complete |
| rxc | output | 1 | Received character waiting |
| ovf | output | 1 | Receive overflow |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
A table runs one character through each of the four clock modes. Each mode is paired with a different combination of bit order, character size and divider value. A loopback with an optional inverter feeds `miso`, so a result that only echoes the transmit register is caught. Separately, a model of the slave decodes `mosi` on the sampling edge that the mode calls for. A swapped edge, a reversed order or a dropped ninth bit therefore shows up as a wrong captured word. Directed sequences cover:
- a back-to-back pair with an extra write while the holding register is full, which separates overflow from ignored writes and measures gap-free clocking;
- a frame with the receiver disabled;
- a frame with slave select disabled.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;

    // Engine activity: either waiting for a character or clocking a frame.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } eng_state_e;

    localparam int DEF_CHAR_W = 9;
    localparam int DEF_BAUD_W = 8;

endpackage

// File: rtl/spi_dbuf_baudgen.sv
module spi_dbuf_baudgen #(
    parameter int BAUD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [BAUD_W-1:0] baud,
    output logic              tick
);

    typedef struct packed {
        logic [BAUD_W-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    // One tick every baud+1 clocks while running; the count restarts from
    // zero whenever the engine is idle so the first edge is a full half-period away.
    always_comb begin
        div_d = div_q;
        tick  = run && (div_q.cnt >= baud);
        if (!run || tick) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

endmodule

// File: rtl/spi_dbuf_shifter.sv
module spi_dbuf_shifter #(
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_data,
    input  logic              edge_tick,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              nine_bit,
    input  logic              miso,
    output logic              mosi,
    output logic              phase,
    output logic              last_edge,
    output logic [CHAR_W-1:0] frame_word
);

    localparam int EDGES_MAX = 2 * CHAR_W;
    localparam int ECNT_W    = $clog2(EDGES_MAX);
    localparam logic [ECNT_W-1:0] LAST_LONG  = ECNT_W'(EDGES_MAX - 1);
    localparam logic [ECNT_W-1:0] LAST_SHORT = ECNT_W'(EDGES_MAX - 3);

    typedef struct packed {
        logic [CHAR_W-1:0] tx;
        logic [CHAR_W-1:0] rx;
        logic [ECNT_W-1:0] ecnt;
        logic              ph;
    } sh_t;

    sh_t sh_d, sh_q;

    logic [ECNT_W-1:0] last_idx;
    logic              odd_edge;
    logic              do_sample;
    logic              do_shift;
    logic [CHAR_W-1:0] rx_in;
    logic [CHAR_W-1:0] rx_nxt;

    always_comb begin
        last_idx  = nine_bit ? LAST_LONG : LAST_SHORT;
        odd_edge  = sh_q.ecnt[0];
        // Even edges are leading, odd edges trailing. Phase 0 samples on
        // leading edges; phase 1 samples on trailing edges.
        do_sample = edge_tick && (odd_edge == cpha);
        // Setup happens on the other edge; with phase 1 the very first leading
        // edge keeps the bit presented at load time.
        do_shift  = edge_tick && (cpha ? (!odd_edge && (sh_q.ecnt != '0)) : odd_edge);

        if (lsb_first) begin
            if (nine_bit) begin
                rx_in = {miso, sh_q.rx[CHAR_W-1:1]};
            end else begin
                rx_in = {1'b0, miso, sh_q.rx[CHAR_W-2:1]};
            end
        end else begin
            rx_in = {sh_q.rx[CHAR_W-2:0], miso};
        end
        rx_nxt     = do_sample ? rx_in : sh_q.rx;
        frame_word = rx_nxt;
        last_edge  = edge_tick && (sh_q.ecnt == last_idx);

        if (lsb_first) begin
            mosi = sh_q.tx[0];
        end else begin
            mosi = nine_bit ? sh_q.tx[CHAR_W-1] : sh_q.tx[CHAR_W-2];
        end
        phase = sh_q.ph;

        sh_d    = sh_q;
        sh_d.rx = rx_nxt;
        if (edge_tick) begin
            sh_d.ph   = ~sh_q.ph;
            sh_d.ecnt = last_edge ? '0 : sh_q.ecnt + 1'b1;
        end
        if (do_shift) begin
            sh_d.tx = lsb_first ? (sh_q.tx >> 1) : (sh_q.tx << 1);
        end
        if (load) begin
            sh_d.tx   = load_data;
            sh_d.rx   = '0;
            sh_d.ecnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    AST_EDGE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.ecnt <= last_idx) else $error("edge index beyond frame"); // R4

    AST_PHASE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        last_edge |=> !sh_q.ph) else $error("sck not home after frame"); // R6

endmodule

// File: rtl/spi_dbuf_rxbuf.sv
module spi_dbuf_rxbuf #(
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [CHAR_W-1:0] frame_word,
    input  logic              rx_en,
    input  logic              rd_en,
    input  logic              ovf_clr,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rxc,
    output logic              ovf
);

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              full;
        logic              ovf;
    } rxb_t;

    rxb_t rxb_d, rxb_q;

    always_comb begin
        rxb_d = rxb_q;
        if (rd_en) begin
            rxb_d.full = 1'b0;
        end
        if (ovf_clr) begin
            rxb_d.ovf = 1'b0;
        end
        if (frame_done && rx_en) begin
            rxb_d.data = frame_word;
            rxb_d.full = 1'b1;
            // The newest character wins; a pending unread one is lost.
            if (rxb_q.full && !rd_en) begin
                rxb_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxb_q <= '0;
        end else begin
            rxb_q <= rxb_d;
        end
    end

    assign rd_data = rxb_q.full ? rxb_q.data : '0;
    assign rxc     = rxb_q.full;
    assign ovf     = rxb_q.ovf;

    AST_OVF_ON_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_en && rxc && !rd_en) |=> ovf) else $error("lost character not flagged"); // R7

    AST_RX_OFF_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rxc) |=> !rxc) else $error("capture while receiver off"); // R3

endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
    import spi_dbuf_pkg::*;
#(
    parameter int CHAR_W = DEF_CHAR_W,
    parameter int BAUD_W = DEF_BAUD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic              cfg_nine_bit,
    input  logic              cfg_rx_en,
    input  logic              cfg_ss_en,
    input  logic [BAUD_W-1:0] cfg_baud,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              ovf_clr,
    output logic [CHAR_W-1:0] rd_data,
    output logic              dre,
    output logic              txc,
    output logic              rxc,
    output logic              ovf,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);

    localparam logic [CHAR_W-1:0] SHORT_MASK = {1'b0, {(CHAR_W-1){1'b1}}};

    typedef struct packed {
        eng_state_e        state;
        logic [CHAR_W-1:0] hold;
        logic              hold_full;
        logic              txc;
        logic              ss_n;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              tick;
    logic              load;
    logic              accept;
    logic              last_edge;
    logic              phase;
    logic [CHAR_W-1:0] frame_word;

    spi_dbuf_baudgen #(.BAUD_W(BAUD_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl_q.state == ST_RUN),
        .baud  (cfg_baud),
        .tick  (tick)
    );

    spi_dbuf_shifter #(.CHAR_W(CHAR_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_data  (ctl_q.hold),
        .edge_tick  (tick),
        .cpha       (cfg_cpha),
        .lsb_first  (cfg_lsb_first),
        .nine_bit   (cfg_nine_bit),
        .miso       (miso),
        .mosi       (mosi),
        .phase      (phase),
        .last_edge  (last_edge),
        .frame_word (frame_word)
    );

    spi_dbuf_rxbuf #(.CHAR_W(CHAR_W)) u_rxbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (last_edge),
        .frame_word (frame_word),
        .rx_en      (cfg_rx_en),
        .rd_en      (rd_en),
        .ovf_clr    (ovf_clr),
        .rd_data    (rd_data),
        .rxc        (rxc),
        .ovf        (ovf)
    );

    always_comb begin
        ctl_d  = ctl_q;
        load   = 1'b0;
        accept = wr_en && !ctl_q.hold_full;
        case (ctl_q.state)
            ST_IDLE: begin
                if (ctl_q.hold_full) begin
                    load            = 1'b1;
                    ctl_d.hold_full = 1'b0;
                    ctl_d.state     = ST_RUN;
                    ctl_d.ss_n      = !cfg_ss_en;
                end
            end
            ST_RUN: begin
                if (last_edge) begin
                    if (ctl_q.hold_full) begin
                        // Back-to-back: next character enters on the final edge.
                        load            = 1'b1;
                        ctl_d.hold_full = 1'b0;
                    end else begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.txc   = 1'b1;
                        ctl_d.ss_n  = 1'b1;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
        if (accept) begin
            ctl_d.hold      = cfg_nine_bit ? wr_data : (wr_data & SHORT_MASK);
            ctl_d.hold_full = 1'b1;
            ctl_d.txc       = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state     <= ST_IDLE;
            ctl_q.hold      <= '0;
            ctl_q.hold_full <= 1'b0;
            ctl_q.txc       <= 1'b0;
            ctl_q.ss_n      <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dre  = !ctl_q.hold_full;
    assign txc  = ctl_q.txc;
    assign ss_n = ctl_q.ss_n;
    assign sck  = cfg_cpol ^ phase;

    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_IDLE) |-> (sck == cfg_cpol)) else $error("sck off idle level"); // R6

    AST_TXC_SS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        txc |-> ss_n) else $error("select low after completion"); // R10

    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctl_q.hold_full) |=> (ctl_q.hold == $past(ctl_q.hold))) else $error("pending character corrupted"); // R11

    AST_DRE_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.hold_full && ctl_q.state == ST_IDLE) |=> dre) else $error("holding register not drained"); // R1

    AST_B2B_CONTINUE: assert property (@(posedge clk) disable iff (!rst_n)
        (last_edge && ctl_q.hold_full) |=> (ctl_q.state == ST_RUN && !txc)) else $error("gap between frames"); // R2

endmodule

// File: tb/spi_dbuf_master_bench.sv
module spi_dbuf_master_bench;

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic       lsb;
        logic       nine;
        logic       inv;
        logic [7:0] baud;
        logic [8:0] data;
    } vec_t;

    // cpol, cpha, lsb_first, nine_bit, invert loopback, baud, data
    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 9'h0A5},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd0, 9'h03C},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2, 9'h0C1},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd1, 9'h17E},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 9'h1A3},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd3, 9'h155},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd1, 9'h102},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'd0, 9'h0FF}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_nine_bit = 1'b0;
    logic       cfg_rx_en = 1'b1, cfg_ss_en = 1'b1;
    logic [7:0] cfg_baud = 8'd1;
    logic       wr_en = 1'b0, rd_en = 1'b0, ovf_clr = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       dre, txc, rxc, ovf, sck, mosi, miso, ss_n;
    logic       inv_sel = 1'b0;

    assign miso = mosi ^ inv_sel;

    always #10 clk = ~clk;

    spi_dbuf_master u_spi_dbuf_master (
        .clk(clk), .rst_n(rst_n),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .cfg_nine_bit(cfg_nine_bit), .cfg_rx_en(cfg_rx_en), .cfg_ss_en(cfg_ss_en),
        .cfg_baud(cfg_baud), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .ovf_clr(ovf_clr), .rd_data(rd_data), .dre(dre), .txc(txc), .rxc(rxc),
        .ovf(ovf), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Slave-side monitor: decodes mosi on the sampling edge, measures timing.
    logic       mon_clr = 1'b1;
    logic       prev_sck = 1'b0, prev_mosi = 1'b0, prev_ss = 1'b1;
    logic [8:0] sh_w;
    logic [8:0] cap [4];
    int nb, ncap, ss_rises, lead_meas, hp_min, hp_max, t_ss, t_last, hp, nbits;
    bit first;

    always @(negedge clk) begin
        if (mon_clr) begin
            nb = 0; sh_w = '0; ncap = 0; ss_rises = 0; lead_meas = -1;
            hp_min = 1000000; hp_max = 0; first = 1'b0;
        end else begin
            if (prev_ss && !ss_n) begin
                t_ss = cyc;
                first = 1'b1;
            end
            if (!prev_ss && ss_n) ss_rises++;
            if (sck != prev_sck) begin
                if (first) begin
                    lead_meas = cyc - t_ss;
                    first = 1'b0;
                end else if (!ss_n) begin
                    hp = cyc - t_last;
                    if (hp < hp_min) hp_min = hp;
                    if (hp > hp_max) hp_max = hp;
                end
                t_last = cyc;
                if ((sck == 1'b1) == (cfg_cpol == cfg_cpha)) begin
                    nbits = cfg_nine_bit ? 9 : 8;
                    if (cfg_lsb_first) sh_w[nb] = prev_mosi;
                    else sh_w = {sh_w[7:0], prev_mosi};
                    nb++;
                    if (nb == nbits) begin
                        if (ncap < 4) cap[ncap] = sh_w;
                        ncap++;
                        nb = 0;
                        sh_w = '0;
                    end
                end
            end
        end
        prev_sck = sck;
        prev_mosi = mosi;
        prev_ss = ss_n;
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic clear_mon;
        mon_clr = 1'b1;
        @(negedge clk);
        @(posedge clk);
        mon_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_write(input logic [8:0] v);
        while (!dre) @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_txc;
        while (!txc) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pop;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        logic [8:0] exp_tx, exp_rx;
        cfg_cpol = v.cpol; cfg_cpha = v.cpha; cfg_lsb_first = v.lsb;
        cfg_nine_bit = v.nine; cfg_baud = v.baud; inv_sel = v.inv;
        cfg_ss_en = 1'b1; cfg_rx_en = 1'b1;
        clear_mon();
        exp_tx = v.nine ? v.data : {1'b0, v.data[7:0]};
        exp_rx = v.inv ? (v.nine ? ~v.data : {1'b0, ~v.data[7:0]}) : exp_tx;
        host_write(v.data);
        chk(dre == 1'b0, "R1 dre low while held", dre, 0);
        @(negedge clk);
        chk(dre == 1'b1, "R1 dre back after move", dre, 1);
        chk(txc == 1'b0, "R1 txc cleared by write", txc, 0);
        wait_txc();
        chk(ncap == 1 && cap[0] == exp_tx, "R5 R4 R6 mosi word", cap[0], exp_tx);
        chk(rxc == 1'b1, "R3 rxc after frame", rxc, 1);
        chk(rd_data == exp_rx, "R3 R4 received word", rd_data, exp_rx);
        chk(sck == v.cpol, "R6 sck idle level", sck, v.cpol);
        chk(ss_n == 1'b1 && txc == 1'b1, "R10 select released with txc", ss_n, 1);
        chk(hp_min == v.baud + 1 && hp_max == v.baud + 1, "R9 half period", hp_max, v.baud + 1);
        chk(lead_meas == v.baud + 1, "R10 select lead", lead_meas, v.baud + 1);
        pop();
        chk(rxc == 1'b0 && rd_data == 9'h000, "R8 empty after read", rd_data, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(dre == 1'b1 && txc == 1'b0, "R12 dre/txc", {dre, txc}, 2);
        chk(rxc == 1'b0 && ovf == 1'b0, "R12 rxc/ovf", {rxc, ovf}, 0);
        chk(ss_n == 1'b1 && sck == 1'b0, "R12 ss/sck", {ss_n, sck}, 2);
        chk(rd_data == 9'h000, "R12 rd_data", rd_data, 0);

        for (int i = 0; i < 8; i++) run_vec(VECS[i]);

        // R2 / R11 / R7: back-to-back pair plus an ignored write.
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0; cfg_nine_bit = 1'b0;
        cfg_baud = 8'd1; inv_sel = 1'b0; cfg_ss_en = 1'b1; cfg_rx_en = 1'b1;
        clear_mon();
        host_write(9'h033);
        @(negedge clk);
        host_write(9'h0C6);
        chk(dre == 1'b0, "R11 holding full", dre, 0);
        wr_en = 1'b1;
        wr_data = 9'h0F0;
        @(negedge clk);
        wr_en = 1'b0;
        wait_txc();
        chk(ncap == 2, "R2 two frames", ncap, 2);
        chk(cap[0] == 9'h033, "R2 first frame", cap[0], 9'h033);
        chk(cap[1] == 9'h0C6, "R11 pending kept", cap[1], 9'h0C6);
        chk(ss_rises == 1, "R2 select held across frames", ss_rises, 1);
        chk(hp_min == 2 && hp_max == 2, "R2 no gap", hp_max, 2);
        chk(ovf == 1'b1, "R7 overflow set", ovf, 1);
        chk(rd_data == 9'h0C6, "R7 newest kept", rd_data, 9'h0C6);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk(ovf == 1'b0, "R7 overflow cleared", ovf, 0);
        chk(rxc == 1'b1, "R7 clear leaves rxc", rxc, 1);
        pop();
        chk(rxc == 1'b0 && rd_data == 9'h000, "R8 read empties", rd_data, 0);

        // R3: receiver disabled.
        cfg_rx_en = 1'b0;
        clear_mon();
        host_write(9'h05A);
        wait_txc();
        chk(rxc == 1'b0, "R3 nothing captured", rxc, 0);
        chk(rd_data == 9'h000, "R8 no valid data", rd_data, 0);
        chk(ncap == 1 && cap[0] == 9'h05A, "R3 transmit still runs", cap[0], 9'h05A);
        cfg_rx_en = 1'b1;

        // R10: slave select disabled.
        cfg_ss_en = 1'b0;
        clear_mon();
        host_write(9'h081);
        repeat (4) @(negedge clk);
        chk(ss_n == 1'b1, "R10 select idle mid frame", ss_n, 1);
        wait_txc();
        chk(lead_meas == -1 && ss_n == 1'b1, "R10 select never low", lead_meas, -1);
        chk(ncap == 1 && cap[0] == 9'h081, "R10 frame sent", cap[0], 9'h081);
        pop();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule